// File: doc/BRIEF.md
# Multiplexed-Bus Port I/O Instruction Sequencer

This block is a small bus controller for an 8-bit processor. It fetches two-byte port transfer instructions from memory and executes them over a bus whose low address byte and data byte share the same pins. It holds a 16-bit program counter and an 8-bit accumulator. The outputs are a high address byte, the shared low address/data byte with its output enable, an address latch enable strobe, a memory-or-I/O select and active-low read and write strobes. The shared byte is split into `ad_o`, `ad_i` and `ad_oe_o`; the pad or the bus fabric around the block merges them.

Work is organised into machine cycles of three clock states each. These are T1, the address state, T2, the transfer state, and T3, the completion state. There are four machine-cycle states: FETCH (opcode read from memory at PC), OPER (operand read from memory at the next PC), IORD (port read) and IOWR (port write). The transitions run FETCH to OPER when the opcode is a port transfer, and FETCH to FETCH for any other opcode. OPER goes to IORD for the port input opcode (0xDB) and to IOWR for the port output opcode (0xD3). IORD and IOWR both return to FETCH. The T-state moves T1 to T2 to T3 and back to T1. The machine-cycle state changes only on the T3 to T1 step.

Top module: `mux_io_seq`

## Requirements
- R1: While reset is held, the program counter and accumulator read zero and the sequencer sits in T1 of FETCH: ALE high, select low, both strobes high.
- R2: Every machine cycle lasts three clocks, and ALE is high only in its first clock (T1).
- R3: In FETCH T1, the high byte of PC goes on `addr_hi_o` and the low byte on `ad_o` with the output enable high and the select low. In T2, `rd_n_o` is low, and the byte on `ad_i` is taken as the opcode.
- R4: For opcode 0xDB or 0xD3, the next machine cycle is a memory read (select low, read strobe low in T2) at the address one above the opcode's address. It returns the 8-bit port number.
- R5: In T1 of a port cycle, the port number is driven on both `addr_hi_o` and `ad_o`, and the select is high for the whole cycle.
- R6: For opcode 0xDB, the port cycle is a read with `rd_n_o` low in T2, and the byte on `ad_i` in T2 is loaded into the accumulator.
- R7: For opcode 0xD3, the port cycle drives the accumulator on `ad_o` in T2 and T3 and pulls `wr_n_o` low only in T3. The accumulator is left unchanged.
- R8: `rd_n_o` and `wr_n_o` are never low together, and the output enable is low whenever `rd_n_o` is low.
- R9: PC rises by one after each byte fetched, including carry into the high byte. After a port instruction it points two past the opcode.
- R10: Any other opcode is a one-machine-cycle no-operation. PC rises by one, the accumulator is kept, and the next cycle is a FETCH.
- R11: `addr_hi_o` and the select hold their T1 values through T2 and T3 of the same machine cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_hi_o | output | 8 | High address byte |
| ad_o | output | 8 | Shared low address / write data byte |
| ad_oe_o | output | 1 | High when the block drives the shared byte |
| ad_i | input | 8 | Read data from memory or port |
| ale_o | output | 1 | Address latch enable, high in T1 |
| io_m_o | output | 1 | High for a port cycle, low for a memory cycle |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| acc_o | output | 8 | Accumulator value |
| pc_o | output | 16 | Program counter value |

## Verification
The outputs decode the registered T-state, so each bus value is due in the same clock as its T-state. The bench samples one time unit after each falling edge and steps through T1, T2 and T3 of every machine cycle in turn. Captured bytes are loaded at the T2-to-T3 edge, and PC advances at the T3-to-T1 edge. Accumulator and PC checks are therefore made only at the next machine cycle's T1, which is one full machine cycle after the read strobe. A port write is recorded by a bus monitor during T3 and compared once the cycle ends.

// File: rtl/mux_io_seq_pkg.sv
package mux_io_seq_pkg;

    typedef enum logic [1:0] {
        TS_T1 = 2'd0,
        TS_T2 = 2'd1,
        TS_T3 = 2'd2
    } tstate_e;

    typedef enum logic [1:0] {
        MC_FETCH = 2'd0,
        MC_OPER  = 2'd1,
        MC_IORD  = 2'd2,
        MC_IOWR  = 2'd3
    } mcyc_e;

    typedef struct packed {
        logic ale;
        logic io_m;
        logic rd_n;
        logic wr_n;
        logic ad_oe;
    } busctl_t;

    localparam busctl_t BUS_IDLE = '{ale: 1'b0, io_m: 1'b0, rd_n: 1'b1,
                                     wr_n: 1'b1, ad_oe: 1'b0};

endpackage

// File: rtl/mux_io_seq_ctrl.sv
module mux_io_seq_ctrl
    import mux_io_seq_pkg::*;
#(
    parameter int          DW     = 8,
    parameter logic [DW-1:0] OP_IN  = 8'hDB,
    parameter logic [DW-1:0] OP_OUT = 8'hD3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] opcode,
    output mcyc_e         mcyc,
    output tstate_e       tst,
    output logic          cap_opcode,
    output logic          cap_port,
    output logic          cap_acc,
    output logic          pc_step
);

    mcyc_e   mcyc_nx;
    tstate_e tst_nx;

    function automatic mcyc_e follow(input mcyc_e cur, input logic [DW-1:0] op);
        mcyc_e nx;
        nx = MC_FETCH;
        unique case (cur)
            MC_FETCH: nx = ((op == OP_IN) || (op == OP_OUT)) ? MC_OPER : MC_FETCH;
            MC_OPER:  nx = (op == OP_IN) ? MC_IORD : MC_IOWR;
            MC_IORD:  nx = MC_FETCH;
            MC_IOWR:  nx = MC_FETCH;
            default:  nx = MC_FETCH;
        endcase
        return nx;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcyc <= MC_FETCH;
            tst  <= TS_T1;
        end else begin
            mcyc <= mcyc_nx;
            tst  <= tst_nx;
        end
    end

    // next state
    always_comb begin
        mcyc_nx = mcyc;
        tst_nx  = tst;
        unique case (tst)
            TS_T1: tst_nx = TS_T2;
            TS_T2: tst_nx = TS_T3;
            TS_T3: begin
                tst_nx  = TS_T1;
                mcyc_nx = follow(mcyc, opcode);
            end
            default: tst_nx = TS_T1;
        endcase
    end

    // capture strobes for the datapath
    always_comb begin
        cap_opcode = (tst == TS_T2) && (mcyc == MC_FETCH);
        cap_port   = (tst == TS_T2) && (mcyc == MC_OPER);
        cap_acc    = (tst == TS_T2) && (mcyc == MC_IORD);
        pc_step    = (tst == TS_T3) && ((mcyc == MC_FETCH) || (mcyc == MC_OPER));
    end

endmodule

// File: rtl/mux_io_seq_dp.sv
module mux_io_seq_dp #(
    parameter int DW = 8,
    parameter logic [2*DW-1:0] PC_RST  = '0,
    parameter logic [DW-1:0]   ACC_RST = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   ad_i,
    input  logic            cap_opcode,
    input  logic            cap_port,
    input  logic            cap_acc,
    input  logic            pc_step,
    output logic [2*DW-1:0] pc,
    output logic [DW-1:0]   opcode,
    output logic [DW-1:0]   port,
    output logic [DW-1:0]   acc
);

    localparam int AW = 2 * DW;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= PC_RST;
            opcode <= '0;
            port   <= '0;
            acc    <= ACC_RST;
        end else begin
            if (cap_opcode) opcode <= ad_i;
            if (cap_port)   port   <= ad_i;
            if (cap_acc)    acc    <= ad_i;
            if (pc_step)    pc     <= pc + AW'(1);
        end
    end

endmodule

// File: rtl/mux_io_seq_drv.sv
module mux_io_seq_drv
    import mux_io_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  mcyc_e           mcyc,
    input  tstate_e         tst,
    input  logic [2*DW-1:0] pc,
    input  logic [DW-1:0]   port,
    input  logic [DW-1:0]   acc,
    output logic [DW-1:0]   addr_hi,
    output logic [DW-1:0]   ad_out,
    output busctl_t         ctl
);

    logic            is_io;
    logic            is_wr;
    logic [2*DW-1:0] cyc_addr;

    always_comb begin
        is_io    = (mcyc == MC_IORD) || (mcyc == MC_IOWR);
        is_wr    = (mcyc == MC_IOWR);
        cyc_addr = is_io ? {port, port} : pc;
    end

    // output process
    always_comb begin
        ctl      = BUS_IDLE;
        ctl.io_m = is_io;
        addr_hi  = cyc_addr[2*DW-1:DW];
        ad_out   = '0;
        unique case (tst)
            TS_T1: begin
                ctl.ale   = 1'b1;
                ctl.ad_oe = 1'b1;
                ad_out    = cyc_addr[DW-1:0];
            end
            TS_T2: begin
                if (is_wr) begin
                    ctl.ad_oe = 1'b1;
                    ad_out    = acc;
                end else begin
                    ctl.rd_n  = 1'b0;
                end
            end
            TS_T3: begin
                if (is_wr) begin
                    ctl.ad_oe = 1'b1;
                    ad_out    = acc;
                    ctl.wr_n  = 1'b0;
                end
            end
            default: ctl = BUS_IDLE;
        endcase
    end

endmodule

// File: rtl/mux_io_seq.sv
module mux_io_seq
    import mux_io_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [DW-1:0]   OP_IN   = 8'hDB,
    parameter logic [DW-1:0]   OP_OUT  = 8'hD3,
    parameter logic [2*DW-1:0] PC_RST  = '0,
    parameter logic [DW-1:0]   ACC_RST = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [DW-1:0]   addr_hi_o,
    output logic [DW-1:0]   ad_o,
    output logic            ad_oe_o,
    input  logic [DW-1:0]   ad_i,
    output logic            ale_o,
    output logic            io_m_o,
    output logic            rd_n_o,
    output logic            wr_n_o,
    output logic [DW-1:0]   acc_o,
    output logic [2*DW-1:0] pc_o
);

    mcyc_e           mcyc;
    tstate_e         tst;
    logic            cap_opcode, cap_port, cap_acc, pc_step;
    logic [2*DW-1:0] pc;
    logic [DW-1:0]   opcode, port, acc;
    busctl_t         ctl;

    mux_io_seq_ctrl #(.DW(DW), .OP_IN(OP_IN), .OP_OUT(OP_OUT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .opcode     (opcode),
        .mcyc       (mcyc),
        .tst        (tst),
        .cap_opcode (cap_opcode),
        .cap_port   (cap_port),
        .cap_acc    (cap_acc),
        .pc_step    (pc_step)
    );

    mux_io_seq_dp #(.DW(DW), .PC_RST(PC_RST), .ACC_RST(ACC_RST)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ad_i       (ad_i),
        .cap_opcode (cap_opcode),
        .cap_port   (cap_port),
        .cap_acc    (cap_acc),
        .pc_step    (pc_step),
        .pc         (pc),
        .opcode     (opcode),
        .port       (port),
        .acc        (acc)
    );

    mux_io_seq_drv #(.DW(DW)) u_drv (
        .mcyc    (mcyc),
        .tst     (tst),
        .pc      (pc),
        .port    (port),
        .acc     (acc),
        .addr_hi (addr_hi_o),
        .ad_out  (ad_o),
        .ctl     (ctl)
    );

    always_comb begin
        ale_o   = ctl.ale;
        io_m_o  = ctl.io_m;
        rd_n_o  = ctl.rd_n;
        wr_n_o  = ctl.wr_n;
        ad_oe_o = ctl.ad_oe;
        acc_o   = acc;
        pc_o    = pc;
    end

endmodule

// File: rtl/mux_io_seq_chk.sv
module mux_io_seq_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] addr_hi_o,
    input logic [DW-1:0] ad_o,
    input logic          ad_oe_o,
    input logic          ale_o,
    input logic          io_m_o,
    input logic          rd_n_o,
    input logic          wr_n_o,
    input logic [DW-1:0] acc_o
);

    assert_ale_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o ##1 !ale_o);

    assert_rw_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o));

    assert_rd_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !ad_oe_o);

    assert_port_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_o && io_m_o) |-> (addr_hi_o == ad_o));

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> $stable(addr_hi_o) && $stable(io_m_o));

    assert_wr_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> ad_oe_o && io_m_o && $stable(ad_o) && $stable(acc_o));

endmodule

bind mux_io_seq mux_io_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_hi_o (addr_hi_o),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .ale_o     (ale_o),
    .io_m_o    (io_m_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .acc_o     (acc_o)
);

// File: tb/test_mux_io_seq.sv
`timescale 1ns/1ps
module test_mux_io_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr_hi_o, ad_o, ad_i, acc_o;
    logic        ad_oe_o, ale_o, io_m_o, rd_n_o, wr_n_o;
    logic [15:0] pc_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  mem [512];
    logic [15:0] lat_addr = '0;
    logic        lat_iom = 1'b0;
    logic [7:0]  wr_port = '0;
    logic [7:0]  wr_data = '0;
    int          wr_cnt = 0;

    always #10 clk = ~clk;

    mux_io_seq i_mux_io_seq (
        .clk(clk), .rst_n(rst_n), .addr_hi_o(addr_hi_o), .ad_o(ad_o),
        .ad_oe_o(ad_oe_o), .ad_i(ad_i), .ale_o(ale_o), .io_m_o(io_m_o),
        .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .acc_o(acc_o), .pc_o(pc_o)
    );

    // memory and port model: address latched while ALE is high
    always @(negedge clk) begin
        if (ale_o) begin
            lat_addr <= {addr_hi_o, ad_o};
            lat_iom  <= io_m_o;
        end
        if (!wr_n_o) begin
            wr_port <= lat_addr[7:0];
            wr_data <= ad_o;
            wr_cnt  <= wr_cnt + 1;
        end
    end

    function automatic logic [7:0] port_val(input logic [7:0] p);
        return p ^ 8'hA5;
    endfunction

    assign ad_i = lat_iom ? port_val(lat_addr[7:0]) : mem[lat_addr[8:0]];

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // kind: 0 memory read, 1 port read, 2 port write
    task automatic do_mc(input string req, input int kind, input logic [15:0] addr,
                         input logic [7:0] wdata);
        logic io;
        io = (kind != 0);
        chk({req, " T1 ale/R2"}, 16'(ale_o), 16'h1);
        chk({req, " T1 addr"}, {addr_hi_o, ad_o}, addr);
        chk({req, " T1 oe"}, 16'(ad_oe_o), 16'h1);
        chk({req, " T1 sel"}, 16'(io_m_o), 16'(io));
        chk({req, " T1 strobes"}, {14'd0, rd_n_o, wr_n_o}, 16'h3);
        step();
        chk({req, " T2 ale/R2"}, 16'(ale_o), 16'h0);
        chk({req, " T2 hold/R11"}, {7'd0, io_m_o, addr_hi_o}, {7'd0, io, addr[15:8]});
        if (kind == 2) begin
            chk({req, " T2 wdata/R7"}, {7'd0, ad_oe_o, ad_o}, {8'h01, wdata});
            chk({req, " T2 strobes/R7"}, {14'd0, rd_n_o, wr_n_o}, 16'h3);
        end else begin
            chk({req, " T2 read/R8"}, {14'd0, rd_n_o, ad_oe_o}, 16'h0);
            chk({req, " T2 wr_n"}, 16'(wr_n_o), 16'h1);
        end
        step();
        chk({req, " T3 ale/R2"}, 16'(ale_o), 16'h0);
        chk({req, " T3 hold/R11"}, {7'd0, io_m_o, addr_hi_o}, {7'd0, io, addr[15:8]});
        if (kind == 2) begin
            chk({req, " T3 write/R7"}, {6'd0, rd_n_o, wr_n_o, ad_o}, {8'h02, wdata});
        end else begin
            chk({req, " T3 strobes"}, {14'd0, rd_n_o, wr_n_o}, 16'h3);
        end
        step();
    endtask

    task automatic t_in(input logic [15:0] pc, input logic [7:0] port, input logic [7:0] exp_acc);
        int w0;
        w0 = wr_cnt;
        do_mc("R3 fetch", 0, pc, 8'h00);
        do_mc("R4 operand", 0, pc + 16'd1, 8'h00);
        do_mc("R5 port read", 1, {port, port}, 8'h00);
        chk("R6 accumulator", 16'(acc_o), 16'(exp_acc));
        chk("R9 pc after input", pc_o, pc + 16'd2);
        chk("R8 no write during input", 16'(wr_cnt), 16'(w0));
    endtask

    task automatic t_out(input logic [15:0] pc, input logic [7:0] port, input logic [7:0] acc);
        int w0;
        w0 = wr_cnt;
        do_mc("R3 fetch", 0, pc, 8'h00);
        do_mc("R4 operand", 0, pc + 16'd1, 8'h00);
        do_mc("R7 port write", 2, {port, port}, acc);
        chk("R7 one write", 16'(wr_cnt), 16'(w0 + 1));
        chk("R7 written port/data", {wr_port, wr_data}, {port, acc});
        chk("R7 accumulator kept", 16'(acc_o), 16'(acc));
        chk("R9 pc after output", pc_o, pc + 16'd2);
    endtask

    task automatic t_nop(input logic [15:0] pc, input logic [7:0] acc);
        do_mc("R10 nop fetch", 0, pc, 8'h00);
        chk("R10 pc after nop", pc_o, pc + 16'd1);
        chk("R10 accumulator kept", 16'(acc_o), 16'(acc));
        chk("R10 next is fetch", 16'(io_m_o), 16'h0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        mem[0]  = 8'hDB; mem[1]  = 8'h84;
        mem[2]  = 8'hD3; mem[3]  = 8'h01;
        mem[4]  = 8'h00; mem[5]  = 8'h76;
        mem[6]  = 8'hDB; mem[7]  = 8'h10;
        mem[8]  = 8'hD3; mem[9]  = 8'hFF;
        mem[10] = 8'hD3; mem[11] = 8'h42;
        mem[12] = 8'hDB; mem[13] = 8'h00;
        mem[255] = 8'hDB; mem[256] = 8'h33;
        mem[257] = 8'h3C;

        repeat (3) step();
        chk("R1 reset pc", pc_o, 16'h0000);
        chk("R1 reset acc", 16'(acc_o), 16'h0000);
        chk("R1 reset bus", {12'd0, ale_o, io_m_o, rd_n_o, wr_n_o}, 16'hB);
        rst_n = 1'b1;

        t_in(16'h0000, 8'h84, 8'h21);
        t_out(16'h0002, 8'h01, 8'h21);
        t_nop(16'h0004, 8'h21);
        t_nop(16'h0005, 8'h21);
        t_in(16'h0006, 8'h10, 8'hB5);
        t_out(16'h0008, 8'hFF, 8'hB5);
        t_out(16'h000A, 8'h42, 8'hB5);
        t_in(16'h000C, 8'h00, 8'hA5);
        for (int a = 14; a < 255; a++) t_nop(16'(a), 8'hA5);
        // R9: operand crosses into the next 256-byte page
        t_in(16'h00FF, 8'h33, 8'h96);
        t_nop(16'h0101, 8'h96);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule